// File: doc/BRIEF.md
# Self-Calibrating Half-Period Predictor

This block locks a fast-clock timebase to a slow external square wave, the sign of a sensed AC voltage, without following its edges continuously. In a calibration phase it counts fast-clock cycles between two consecutive rising edges of the sign input and stores that count as the period. It then runs open loop. A square wave, `syncOut`, starts high on the edge that ends calibration and toggles at predicted half-period points. Each toggle can be moved earlier by a programmable lead, so that downstream switching begins before the real zero crossing.

An odd measured period cannot be split into two equal integer halves. The block makes the first half of every predicted period the rounded-down half and the second half one count longer. The predicted period therefore equals the measured one, and the rounding never builds up over time.

The sign input and the fast clock are unrelated, so drift is still possible. For that reason the block returns to calibration after a programmable number of full sync periods and raises a one-cycle recalibration request. Calibration spans roughly one and a half to two input periods, and `syncOut` stays low while it runs. A missing second edge, or a period too short to split, raises a fault flag and keeps the block calibrating.

Top module: `halfcycle_sync`

## Requirements
- R1: While reset is asserted, `syncOut` is 0, `calActive` is 1, `recalReq` is 0 and `calFault` is 0.
- R2: A rising edge of `senseSign` is detected at the first clock edge that samples it 1 after it was sampled 0. The measured period P is the number of clock edges between the first and second detected rises. On the second rise, `syncOut` goes to 1 and `calActive` goes to 0, with no added latency. Before that edge, `calActive` is 1 and `syncOut` is 0.
- R3: Let h = floor(P/2). Each predicted period splits into a first half of h clocks and a second half of h + (P mod 2) clocks. Together they last exactly P clocks, so predicted crossings never drift against the measured period. With zero lead, `syncOut` is 1 during the first half and 0 during the second half.
- R4: When `phaseWord` is less than h, each toggle of `syncOut` happens `phaseWord` clocks before the end of its half. Within a period starting at offset 0, the fall is at offset h−`phaseWord` and the rise is at offset 2h+(P mod 2)−`phaseWord`.
- R5: When `phaseWord` is h or more, the toggle point clamps to the first count of each half. `syncOut` falls 1 clock after a period starts and rises 1 clock after its second half starts.
- R6: `recalPeriods` sets N, the number of full sync periods between calibrations; a value of 0 acts as 1. On the clock edge where the Nth period ends, the block re-enters calibration. `recalReq` is 1 for exactly that one cycle, `calActive` rises and `syncOut` is forced to 0.
- R7: While sync is running, `senseSign` has no effect on `syncOut`, including when its period is not an integer number of clocks.
- R8: Suppose the period counter reaches its saturation value of 511 without a second rise. `calFault` is then set on the next clock edge, which is 512 clocks after the first rise. The block stays in calibration with `syncOut` at 0.
- R9: A measured period below 4 clocks is rejected: `calFault` is set on the second rise and the block stays in calibration. A period of exactly 4 is accepted.
- R10: `calFault` stays set until a later calibration succeeds, and it clears on the same edge where `syncOut` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| senseSign | input | 1 | Sign of the sensed AC voltage (1 = positive) |
| phaseWord | input | 8 | Lead, in clocks, applied to each predicted toggle |
| recalPeriods | input | 4 | Full sync periods between calibrations (0 acts as 1) |
| syncOut | output | 1 | Predicted half-cycle square wave |
| calActive | output | 1 | High while measuring the period |
| recalReq | output | 1 | One-cycle pulse when a recalibration begins |
| calFault | output | 1 | Sticky flag for a missing or too-short period |

## Verification
All results are registered, and every result appears after the clock edge that produced it, with no extra pipeline stage. `syncOut` and `calActive` change on the same edge that detects the second rise. Edge E0+t is measured from that rise, and each later toggle lands on one of these edges, at an offset computed from h, P mod 2 and the lead. `recalReq` pulses after edge E0+N·P. The fault flag appears after edge s+512 on a timeout, or after the second rise for a short period. The bench drives `senseSign` at the falling clock edge before edge i and samples outputs at the falling edge after it. Each expected value is therefore a closed-form function of i, the rise cycles it generated and the programmed words.

// File: rtl/hp_pkg.sv
package hp_pkg;

  // Strobes issued by the control unit to the datapath.
  typedef struct packed {
    logic measClear;    // restart period counter at first rise
    logic measRun;      // period counter may advance
    logic latchPeriod;  // store the measured period
    logic runStart;     // begin prediction at the crossing
    logic runEn;        // prediction timebase running
  } hpStrobes_t;

  typedef enum logic [1:0] {
    ST_ARM     = 2'd0,
    ST_MEASURE = 2'd1,
    ST_RUN     = 2'd2
  } hpState_t;

endpackage

// File: rtl/hp_datapath.sv
module hp_datapath
  import hp_pkg::*;
#(
  parameter int CNT_W      = 9,
  parameter int MIN_PERIOD = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             senseSign,
  input  logic [CNT_W-2:0] phaseWord,
  input  hpStrobes_t       str,
  output logic             riseDet,
  output logic             measSat,
  output logic             periodShort,
  output logic             fullEnd,
  output logic             toggleHit
);

  localparam int               PH_W    = CNT_W - 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W:0]   MIN_P   = (CNT_W+1)'(MIN_PERIOD);

  logic             senseQ;
  logic [CNT_W-1:0] measCnt;
  logic [CNT_W:0]   measNext;
  logic [CNT_W-1:0] periodReg;
  logic [PH_W-1:0]  halfP;
  logic [CNT_W-1:0] tcCur;
  logic [CNT_W-1:0] toggleAt;
  logic [CNT_W-1:0] runCnt;
  logic             extraSel;
  logic             halfEnd;

  // Edge detector on the sampled sign input.
  assign riseDet = senseSign & ~senseQ;

  // Measurement arithmetic.
  assign measSat     = (measCnt == CNT_MAX);
  assign measNext    = {1'b0, measCnt} + (CNT_W+1)'(1);
  assign periodShort = (measNext < MIN_P);

  // Half-period terminal: odd periods lengthen every second half.
  assign halfP    = periodReg[CNT_W-1:1];
  assign tcCur    = {1'b0, halfP} + CNT_W'(extraSel & periodReg[0]);
  assign toggleAt = (phaseWord >= halfP) ? CNT_W'(1)
                                         : tcCur - {1'b0, phaseWord};

  assign halfEnd   = (runCnt == tcCur);
  assign fullEnd   = halfEnd & extraSel;
  assign toggleHit = (runCnt == toggleAt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      senseQ <= 1'b0;
    end else begin
      senseQ <= senseSign;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      measCnt <= '0;
    end else if (str.measClear) begin
      measCnt <= '0;
    end else if (str.measRun && !measSat) begin
      measCnt <= measCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodReg <= '0;
    end else if (str.latchPeriod) begin
      periodReg <= measNext[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt   <= '0;
      extraSel <= 1'b0;
    end else if (str.runStart) begin
      runCnt   <= CNT_W'(1);
      extraSel <= 1'b0;
    end else if (str.runEn) begin
      if (halfEnd) begin
        runCnt   <= CNT_W'(1);
        extraSel <= ~extraSel;
      end else begin
        runCnt <= runCnt + CNT_W'(1);
      end
    end
  end

  // R3: the timebase never passes the terminal of its half.
  p_runcnt_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    str.runEn |-> (runCnt >= CNT_W'(1) && runCnt <= tcCur));

  // R3: the lengthened half alternates at each half boundary.
  p_extra_alternate_r3: assert property (@(posedge clk) disable iff (!rstN)
    (str.runEn && halfEnd) |=> (extraSel != $past(extraSel)));

  // R8: the period counter saturates instead of wrapping.
  p_meas_saturate_r8: assert property (@(posedge clk) disable iff (!rstN)
    measSat |=> (measSat || measCnt == '0));

endmodule

// File: rtl/hp_control.sv
module hp_control
  import hp_pkg::*;
#(
  parameter int RC_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [RC_W-1:0] recalPeriods,
  input  logic            riseDet,
  input  logic            measSat,
  input  logic            periodShort,
  input  logic            fullEnd,
  input  logic            toggleHit,
  output hpStrobes_t      str,
  output logic            syncOut,
  output logic            calActive,
  output logic            recalReq,
  output logic            calFault
);

  hpState_t        state;
  logic [RC_W-1:0] recalCnt;
  logic [RC_W-1:0] target;
  logic [RC_W-1:0] doneNext;
  logic            lastPeriod;
  logic            measOk;

  assign target     = (recalPeriods == '0) ? RC_W'(1) : recalPeriods;
  assign doneNext   = recalCnt + RC_W'(1);
  assign lastPeriod = (doneNext == target);
  assign measOk     = riseDet && !measSat && !periodShort;
  assign calActive  = (state != ST_RUN);

  always_comb begin
    str = '0;
    unique case (state)
      ST_ARM: begin
        str.measClear = riseDet;
      end
      ST_MEASURE: begin
        str.measRun     = 1'b1;
        str.latchPeriod = measOk;
        str.runStart    = measOk;
      end
      ST_RUN: begin
        str.runEn = 1'b1;
      end
      default: str = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_ARM;
      syncOut  <= 1'b0;
      recalReq <= 1'b0;
      calFault <= 1'b0;
      recalCnt <= '0;
    end else begin
      recalReq <= 1'b0;
      unique case (state)
        ST_ARM: begin
          if (riseDet) state <= ST_MEASURE;
        end
        ST_MEASURE: begin
          if (measSat || (riseDet && periodShort)) begin
            calFault <= 1'b1;
            state    <= ST_ARM;
          end else if (riseDet) begin
            calFault <= 1'b0;
            syncOut  <= 1'b1;
            recalCnt <= '0;
            state    <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (fullEnd && lastPeriod) begin
            syncOut  <= 1'b0;
            recalReq <= 1'b1;
            state    <= ST_ARM;
          end else begin
            if (toggleHit) syncOut <= ~syncOut;
            if (fullEnd) recalCnt <= doneNext;
          end
        end
        default: state <= ST_ARM;
      endcase
    end
  end

  // R6: sync is held low outside the running state.
  p_idle_sync_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_RUN) |-> !syncOut);

  // R6: the request lasts one cycle.
  p_recal_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    recalReq |=> !recalReq);

  // R6: a request coincides with calibration being active.
  p_recal_cal_r6: assert property (@(posedge clk) disable iff (!rstN)
    recalReq |-> calActive);

  // R8: a fault is only visible while calibrating.
  p_fault_cal_r8: assert property (@(posedge clk) disable iff (!rstN)
    calFault |-> calActive);

endmodule

// File: rtl/halfcycle_sync.sv
module halfcycle_sync
  import hp_pkg::*;
#(
  parameter int CNT_W      = 9,
  parameter int RC_W       = 4,
  parameter int MIN_PERIOD = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             senseSign,
  input  logic [CNT_W-2:0] phaseWord,
  input  logic [RC_W-1:0]  recalPeriods,
  output logic             syncOut,
  output logic             calActive,
  output logic             recalReq,
  output logic             calFault
);

  hpStrobes_t str;
  logic       riseDet;
  logic       measSat;
  logic       periodShort;
  logic       fullEnd;
  logic       toggleHit;

  hp_datapath #(
    .CNT_W      (CNT_W),
    .MIN_PERIOD (MIN_PERIOD)
  ) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .senseSign   (senseSign),
    .phaseWord   (phaseWord),
    .str         (str),
    .riseDet     (riseDet),
    .measSat     (measSat),
    .periodShort (periodShort),
    .fullEnd     (fullEnd),
    .toggleHit   (toggleHit)
  );

  hp_control #(
    .RC_W (RC_W)
  ) i_control (
    .clk          (clk),
    .rstN         (rstN),
    .recalPeriods (recalPeriods),
    .riseDet      (riseDet),
    .measSat      (measSat),
    .periodShort  (periodShort),
    .fullEnd      (fullEnd),
    .toggleHit    (toggleHit),
    .str          (str),
    .syncOut      (syncOut),
    .calActive    (calActive),
    .recalReq     (recalReq),
    .calFault     (calFault)
  );

endmodule

// File: tb/test_halfcycle_sync.sv
module test_halfcycle_sync;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       senseSign = 1'b0;
  logic [7:0] phaseWord = '0;
  logic [3:0] recalPeriods = 4'd1;
  logic       syncOut, calActive, recalReq, calFault;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  halfcycle_sync i_halfcycle_sync (
    .clk          (clk),
    .rstN         (rstN),
    .senseSign    (senseSign),
    .phaseWord    (phaseWord),
    .recalPeriods (recalPeriods),
    .syncOut      (syncOut),
    .calActive    (calActive),
    .recalReq     (recalReq),
    .calFault     (calFault)
  );

  task automatic chk(input string tag, input string what, input int cyc,
                     input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s cyc=%0d act=%0d exp=%0d", tag, what, cyc, act, exp);
    end
  endtask

  // Square wave of period a/b clocks starting high at cycle s.
  function automatic logic waveAt(input int i, input int s, input int a, input int b);
    if (i < s) return 1'b0;
    return (2 * (((i - s) * b) % a)) < a;
  endfunction

  task automatic doReset();
    rstN = 1'b0;
    senseSign = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", "sync", -1, int'(syncOut), 0);
    chk("R1", "calActive", -1, int'(calActive), 1);
    chk("R1", "recalReq", -1, int'(recalReq), 0);
    chk("R1", "calFault", -1, int'(calFault), 0);
    rstN = 1'b1;
  endtask

  task automatic runTrial(input int a, input int b, input int s, input int ph,
                          input int n, input string tag);
    int r2, p, e0, nEff, endC, h, o, a0, a1;
    phaseWord = ph[7:0];
    recalPeriods = n[3:0];
    doReset();
    r2 = s + 1;
    while (!(waveAt(r2, s, a, b) && !waveAt(r2 - 1, s, a, b))) r2++;
    p = r2 - s;
    e0 = r2;
    nEff = (n == 0) ? 1 : n;
    endC = e0 + nEff * p;
    h = p / 2;
    o = p % 2;
    a0 = (ph >= h) ? 1 : h - ph;
    a1 = (ph >= h) ? 1 : h + o - ph;
    for (int i = 0; i <= endC + 1; i++) begin
      int t, r, expS;
      senseSign = waveAt(i, s, a, b);
      @(posedge clk);
      @(negedge clk);
      chk("R8", "calFault", i, int'(calFault), 0);
      if (i < e0) begin
        chk("R2", "calActive", i, int'(calActive), 1);
        chk("R2", "sync", i, int'(syncOut), 0);
      end else if (i < endC) begin
        t = i - e0;
        r = t % p;
        expS = (r < a0) ? 1 : ((r < h + a1) ? 0 : 1);
        chk(tag, "sync", i, int'(syncOut), expS);
        chk("R2", "calActive", i, int'(calActive), 0);
        chk("R6", "recalReq", i, int'(recalReq), 0);
      end else if (i == endC) begin
        chk("R6", "sync", i, int'(syncOut), 0);
        chk("R6", "calActive", i, int'(calActive), 1);
        chk("R6", "recalReq", i, int'(recalReq), 1);
      end else begin
        chk("R6", "recalReq", i, int'(recalReq), 0);
        chk("R6", "calActive", i, int'(calActive), 1);
      end
    end
  endtask

  // R8 and R10: lone rise, saturation, then a good wave.
  task automatic timeoutTrial();
    int s, s2, e0;
    s = 3;
    s2 = s + 600;
    e0 = s2 + 8;
    phaseWord = 8'd0;
    recalPeriods = 4'd2;
    doReset();
    for (int i = 0; i <= e0 + 2; i++) begin
      senseSign = ((i >= s) && (i < s + 2)) || waveAt(i, s2, 8, 1);
      @(posedge clk);
      @(negedge clk);
      if (i < s + 512) begin
        chk("R8", "calFault", i, int'(calFault), 0);
      end else if (i < e0) begin
        chk("R8", "calFault", i, int'(calFault), 1);
        chk("R8", "calActive", i, int'(calActive), 1);
        chk("R8", "sync", i, int'(syncOut), 0);
      end else begin
        chk("R10", "calFault", i, int'(calFault), 0);
        chk("R10", "sync", i, int'(syncOut), 1);
      end
    end
  endtask

  // R9: a 3-clock period is rejected repeatedly.
  task automatic shortTrial();
    int s;
    s = 2;
    phaseWord = 8'd0;
    recalPeriods = 4'd1;
    doReset();
    for (int i = 0; i <= 40; i++) begin
      senseSign = waveAt(i, s, 3, 1);
      @(posedge clk);
      @(negedge clk);
      chk("R9", "calFault", i, int'(calFault), (i >= s + 3) ? 1 : 0);
      chk("R9", "sync", i, int'(syncOut), 0);
      chk("R9", "calActive", i, int'(calActive), 1);
    end
  endtask

  initial begin
    int perList[8] = '{4, 5, 6, 7, 9, 10, 13, 16};
    for (int pi = 0; pi < 8; pi++) begin
      int pv, hv;
      int phList[7];
      pv = perList[pi];
      hv = pv / 2;
      phList = '{0, 1, 2, hv - 1, hv, hv + 3, 255};
      for (int k = 0; k < 7; k++) begin
        for (int n = 1; n <= 2; n++) begin
          int phv;
          string tg;
          phv = phList[k];
          tg = (phv == 0) ? "R3" : ((phv >= hv) ? "R5" : "R4");
          runTrial(pv, 1, 3 + (pi % 3), phv, n, tg);
        end
      end
    end
    runTrial(7, 1, 2, 1, 15, "R4");
    runTrial(9, 1, 4, 0, 0, "R3");
    runTrial(37, 4, 2, 1, 3, "R7");
    runTrial(55, 3, 4, 3, 2, "R7");
    runTrial(23, 2, 1, 0, 4, "R7");
    timeoutTrial();
    shortTrial();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R2 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule